// File: doc/BRIEF.md
# Multiplexed Bus Calibration-Read Snooper

This block listens, without ever driving, to the shared address/data bus of a small 8-bit controller. It keeps a copy of every value the controller reads from a nibble-wide calibration RAM. During the address phase the bus carries the low eight address bits, and at the same moment a port nibble carries a bit whose latched value selects that RAM. The snooper latches both on the leading edge of each address strobe, exactly as the board's own latch does. A read counts only when the read strobe rises while that rebuilt select is low.

Each qualified read stores the low nibble of the bus into a 256 x 4 capture memory at the latched address and marks the location as valid. The block also counts the captures and counts the re-reads that return a different value. A host reads the memory back through a registered port after the controller has finished its start-up pass. All bus inputs are asynchronous to the local sampling clock and pass through two-stage synchronizers first.

Top module: `calbus_snoop`

## Requirements
- R1: On every rising edge of the address strobe `ale`, the current `bus_ad` byte is latched as the address that later reads use.
- R2: On the same `ale` rising edge, `port_hi[3]` is latched as the active-low RAM select. An earlier strobe (for example, one in an instruction-fetch cycle) is superseded by the latest one, so only the value latched last governs a read.
- R3: A read with the latched select high (1) causes no change to the capture memory, the valid map or either counter.
- R4: A qualified read stores `bus_ad[3:0]` as it was while `rd_n` was low, at the latched address, and ignores `bus_ad[7:4]`. It also sets `valid_map[address]`, and that bit stays set until reset.
- R5: `cap_count` rises by exactly one for each qualified read (rising edge of `rd_n` while the latched select is 0) and wraps at its width.
- R6: A qualified read of a location that is already valid overwrites it. `mismatch_count` rises by one when the new nibble differs from the stored one and stays unchanged when they are equal.
- R7: `host_data` shows the stored nibble at `host_addr` one clock after `host_addr` is applied.
- R8: After reset, both counters are 0, `valid_map` is all zero, every memory nibble reads 0, and the latched select is deasserted.
- R9: When `rd_n` rises at the pins, `cap_count` and `valid_map` change at the third rising clock edge after it and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ad | input | 8 | Multiplexed address/data lines of the monitored bus |
| ale | input | 1 | Address strobe, active high |
| rd_n | input | 1 | Read strobe, active low |
| port_hi | input | 4 | Port nibble shared with the address phase; bit 3 is the RAM select |
| host_addr | input | 8 | Host read-back address |
| host_data | output | 4 | Captured nibble at host_addr, registered |
| valid_map | output | 256 | One bit per location, set once captured |
| cap_count | output | 16 | Number of qualified reads seen |
| mismatch_count | output | 16 | Re-reads that returned a different nibble |

## Verification
A read strobe that rises at the pins takes two clocks to cross the synchronizer and one more to be written. For that reason `cap_count` and `valid_map` are due at the third clock edge after the rise, and the bench checks both sides of that edge once. `host_data` is due one edge after `host_addr` changes; every bus transaction is followed by six idle clocks, and every host read waits two edges before sampling. Outputs are sampled on the falling clock edge, away from the edge where they update.

// File: rtl/calbus_pkg.sv
package calbus_pkg;
    localparam int BUS_W  = 8;
    localparam int NIB_W  = 4;
    localparam int PORT_W = 4;
    localparam int SEL_BIT = 3;
    localparam int DEPTH  = 1 << BUS_W;

    typedef logic [BUS_W-1:0] addr_t;
    typedef logic [NIB_W-1:0] nib_t;

    typedef struct packed {
        logic  fire;
        addr_t addr;
        nib_t  nib;
    } cap_evt_t;
endpackage

// File: rtl/calbus_sync.sv
module calbus_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            stg_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/calbus_rebuild.sv
module calbus_rebuild
    import calbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  addr_t             bus_s,
    input  logic              ale_s,
    input  logic              rd_n_s,
    input  logic [PORT_W-1:0] port_s,
    output cap_evt_t          evt
);
    typedef struct packed {
        logic              ale_p;
        logic              rd_p;
        nib_t              nib_p;
        addr_t             addr;
        logic [PORT_W-1:0] port_lat;
    } rb_st_t;

    rb_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.ale_p = ale_s;
        st_d.rd_p  = rd_n_s;
        st_d.nib_p = bus_s[NIB_W-1:0];
        if (ale_s && !st_q.ale_p) begin
            st_d.addr     = bus_s;
            st_d.port_lat = port_s;
        end
        evt.fire = rd_n_s && !st_q.rd_p && !st_q.port_lat[SEL_BIT];
        evt.addr = st_q.addr;
        evt.nib  = st_q.nib_p;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.rd_p     <= 1'b1;
            st_q.port_lat <= '1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/calbus_store.sv
module calbus_store
    import calbus_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cap_evt_t         evt,
    input  addr_t            host_addr,
    output nib_t             host_data,
    output logic [DEPTH-1:0] valid_map,
    output logic [CNT_W-1:0] cap_count,
    output logic [CNT_W-1:0] mismatch_count
);
    typedef struct packed {
        logic [DEPTH-1:0][NIB_W-1:0] mem;
        logic [DEPTH-1:0]            valid;
        logic [CNT_W-1:0]            cnt;
        logic [CNT_W-1:0]            mis;
        nib_t                        rdat;
    } st_st_t;

    st_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.rdat = st_q.mem[host_addr];
        if (evt.fire) begin
            if (st_q.valid[evt.addr] && (st_q.mem[evt.addr] != evt.nib))
                st_d.mis = st_q.mis + 1'b1;
            st_d.mem[evt.addr]   = evt.nib;
            st_d.valid[evt.addr] = 1'b1;
            st_d.cnt             = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign host_data      = st_q.rdat;
    assign valid_map      = st_q.valid;
    assign cap_count      = st_q.cnt;
    assign mismatch_count = st_q.mis;
endmodule

// File: rtl/calbus_snoop.sv
module calbus_snoop
    import calbus_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_W-1:0]  bus_ad,
    input  logic              ale,
    input  logic              rd_n,
    input  logic [PORT_W-1:0] port_hi,
    input  logic [BUS_W-1:0]  host_addr,
    output logic [NIB_W-1:0]  host_data,
    output logic [DEPTH-1:0]  valid_map,
    output logic [CNT_W-1:0]  cap_count,
    output logic [CNT_W-1:0]  mismatch_count
);
    localparam int SYN_W = PORT_W + BUS_W + 2;

    logic [SYN_W-1:0]  raw_w, syn_w;
    addr_t             bus_s;
    logic [PORT_W-1:0] port_s;
    logic              ale_s, rd_n_s;
    cap_evt_t          evt;

    assign raw_w = {port_hi, bus_ad, ale, rd_n};

    calbus_sync #(.W(SYN_W), .STAGES(SYNC_N), .RST_VAL(SYN_W'(1))) sync_i (
        .clk(clk), .rst_n(rst_n), .d(raw_w), .q(syn_w)
    );

    assign {port_s, bus_s, ale_s, rd_n_s} = syn_w;

    calbus_rebuild rebuild_i (
        .clk(clk), .rst_n(rst_n), .bus_s(bus_s), .ale_s(ale_s),
        .rd_n_s(rd_n_s), .port_s(port_s), .evt(evt)
    );

    calbus_store #(.CNT_W(CNT_W)) store_i (
        .clk(clk), .rst_n(rst_n), .evt(evt), .host_addr(host_addr),
        .host_data(host_data), .valid_map(valid_map),
        .cap_count(cap_count), .mismatch_count(mismatch_count)
    );
endmodule

// File: rtl/calbus_snoop_chk.sv
module calbus_snoop_chk #(
    parameter int CNT_W = 16,
    parameter int DEPTH = 256
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_n,
    input logic [DEPTH-1:0] valid_map,
    input logic [CNT_W-1:0] cap_count,
    input logic [CNT_W-1:0] mismatch_count
);
    a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cap_count == $past(cap_count)) || (cap_count == $past(cap_count) + 1'b1));

    a_r6_mismatch_needs_capture: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (mismatch_count == $past(mismatch_count)) || (cap_count != $past(cap_count)));

    a_r4_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((valid_map & $past(valid_map)) == $past(valid_map)));

    a_r4_valid_grows_with_count: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(valid_map) == $countones($past(valid_map))) ||
                 (cap_count == $past(cap_count) + 1'b1));

    a_r9_no_capture_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n && $past(rd_n) && $past(rd_n, 2) && $past(rd_n, 3)) |=> $stable(cap_count));
endmodule

bind calbus_snoop calbus_snoop_chk #(.CNT_W(CNT_W), .DEPTH(calbus_pkg::DEPTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .valid_map(valid_map),
    .cap_count(cap_count), .mismatch_count(mismatch_count)
);

// File: tb/calbus_snoop_tb.sv
module calbus_snoop_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   bus_ad = 8'hFF;
    logic         ale = 1'b0;
    logic         rd_n = 1'b1;
    logic [3:0]   port_hi = 4'hF;
    logic [7:0]   host_addr = 8'h00;
    logic [3:0]   host_data;
    logic [255:0] valid_map;
    logic [15:0]  cap_count, mismatch_count;

    int checks = 0;
    int fails = 0;
    logic [3:0]   exp_mem [256];
    logic [255:0] exp_map = '0;
    int exp_cnt = 0;
    int exp_mis = 0;

    always #4 clk = ~clk;

    calbus_snoop dut_i (
        .clk(clk), .rst_n(rst_n), .bus_ad(bus_ad), .ale(ale), .rd_n(rd_n),
        .port_hi(port_hi), .host_addr(host_addr), .host_data(host_data),
        .valid_map(valid_map), .cap_count(cap_count), .mismatch_count(mismatch_count)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [255:0] got,
                         input logic [255:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // address phase then optional read phase; model updated from R3..R6
    task automatic bus_cycle(input logic [7:0] a, input logic [3:0] p,
                             input logic [7:0] d, input bit do_rd);
        bus_ad = a; port_hi = p; tick(1);
        ale = 1'b1; tick(3);
        ale = 1'b0; tick(1);
        bus_ad = d; tick(1);
        if (do_rd) begin
            rd_n = 1'b0; tick(3);
            rd_n = 1'b1;
            if (!p[3]) begin
                if (exp_map[a] && exp_mem[a] != d[3:0]) exp_mis++;
                exp_mem[a] = d[3:0];
                exp_map[a] = 1'b1;
                exp_cnt++;
            end
        end
        tick(1);
        bus_ad = 8'hFF;
        tick(6);
    endtask

    task automatic host_rd(input logic [7:0] a, output logic [3:0] v);
        host_addr = a; tick(2);
        v = host_data;
    endtask

    task automatic check_counts(input string tag);
        check(cap_count == 16'(exp_cnt), {tag, " cap_count"}, 256'(cap_count), 256'(exp_cnt));
        check(mismatch_count == 16'(exp_mis), {tag, " mismatch_count"},
              256'(mismatch_count), 256'(exp_mis));
        check(valid_map == exp_map, {tag, " valid_map"}, valid_map, exp_map);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [3:0] v;
        for (int i = 0; i < 256; i++) exp_mem[i] = 4'h0;
        tick(3);
        rst_n = 1'b1;
        tick(2);

        // R8 reset state
        check_counts("R8");
        host_rd(8'h00, v);
        check(v == 4'h0, "R8 memory zero", 256'(v), 256'h0);

        // R9 latency: result due at third edge after rd_n rise
        bus_ad = 8'h10; port_hi = 4'h0; tick(1);
        ale = 1'b1; tick(3); ale = 1'b0; tick(1);
        bus_ad = 8'hE5; tick(1);
        rd_n = 1'b0; tick(3);
        rd_n = 1'b1;
        tick(2);
        check(cap_count == 16'd0, "R9 not before third edge", 256'(cap_count), 256'h0);
        tick(1);
        check(cap_count == 16'd1, "R9 at third edge", 256'(cap_count), 256'h1);
        check(valid_map[8'h10] == 1'b1, "R9 valid at third edge", 256'(valid_map[8'h10]), 256'h1);
        exp_mem[8'h10] = 4'h5; exp_map[8'h10] = 1'b1; exp_cnt = 1;
        bus_ad = 8'hFF; tick(6);
        host_rd(8'h10, v);
        check(v == 4'h5, "R4 upper nibble ignored", 256'(v), 256'h5);

        // R3 select high: nothing changes
        bus_cycle(8'h20, 4'h8, 8'h3C, 1'b1);
        check_counts("R3");
        host_rd(8'h20, v);
        check(v == 4'h0, "R3 memory untouched", 256'(v), 256'h0);

        // R2 fetch strobe with select low superseded by strobe with select high
        bus_cycle(8'h30, 4'h7, 8'h00, 1'b0);
        bus_cycle(8'h31, 4'hF, 8'h09, 1'b1);
        check_counts("R2 later strobe deselects");
        // and the converse: fetch with select high, then data strobe with select low
        bus_cycle(8'h40, 4'hC, 8'h00, 1'b0);
        bus_cycle(8'h41, 4'h3, 8'hA7, 1'b1);
        check_counts("R2 later strobe selects");
        host_rd(8'h41, v);
        check(v == 4'h7, "R1 R2 data at latched address", 256'(v), 256'h7);

        // R1 R4 R5 sweep over every address
        for (int a = 0; a < 256; a++)
            bus_cycle(8'(a), {1'b0, 3'(a)}, {4'(a >> 4) ^ 4'hA, 4'((a * 5 + 3) & 15)}, 1'b1);
        check_counts("R5 sweep");
        for (int a = 0; a < 256; a++) begin
            host_rd(8'(a), v);
            check(v == exp_mem[a], "R1 R4 R7 sweep readback", 256'(v), 256'(exp_mem[a]));
        end

        // R6 re-reads: even addresses same value, odd addresses changed
        for (int a = 0; a < 64; a++) begin
            logic [3:0] nv;
            nv = (a % 2 == 0) ? exp_mem[a] : exp_mem[a] + 4'h1;
            bus_cycle(8'(a), 4'h0, {4'h5, nv}, 1'b1);
        end
        check_counts("R6 re-read");
        for (int a = 0; a < 64; a++) begin
            host_rd(8'(a), v);
            check(v == exp_mem[a], "R6 overwrite", 256'(v), 256'(exp_mem[a]));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule